// File: doc/BRIEF.md
# Dual-Slot Split-Owned Register Scoreboard

This block tracks outstanding register writes for every warp of a SIMT core. It keeps two independent reservation slots per warp. Slot 0 serves the primary instruction-buffer half and slot 1 serves the secondary half. Each slot remembers which divergent split owns it and that split's active lane mask. A slot changes owner only after it has fully drained. The slot is then clean for the new split at every divergence, reconvergence or split rotation.

The fetch stage asks for a half with a warp, slot, split id and lane mask. It receives a grant or a stall in the same cycle. On a stall it moves on to another warp. The issue stage names the issue kind and presents source and destination registers. The block reports a hazard or accepts the instruction. Acceptance reserves the destination in the slot that belongs to that kind. The writeback stage releases a destination register in the slot recorded with the instruction, or in a default slot when none was recorded.

Top module: `sb_split_slots`

## Requirements
- R1: After reset every slot of every warp is unassigned and holds no reservation. The owner outputs show no owner, and no register shows a hazard.
- R2: A granted fetch records three things in the addressed slot: the assigned flag, the split id and the lane mask. The owner outputs for that warp and slot show them from the next cycle on.
- R3: A fetch stalls, with no grant, when all three conditions hold: the slot is assigned, its owner split differs from the requesting split, and the slot holds at least one reservation. Once the slot drains, the same request is granted.
- R4: A fetch from the split that already owns the slot is granted whatever reservations the slot holds.
- R5: A fetch into an unassigned slot, or into a clean slot, is granted whatever split asks.
- R6: The issue kind selects the slot. It is encoded as 0 for primary, 1 for intra-warp co-issue and 2 for inter-warp co-issue. Kind 0 uses slot 0 of the issue warp. Kind 1 uses slot 1 of the issue warp. Kind 2 uses slot 0 of the issue warp, which is the donor.
- R7: An issue reports a hazard, and is not accepted, when either source or the destination is reserved in the selected slot. Otherwise it is accepted, and its destination is reserved there from the next cycle.
- R8: A release clears the register in the slot given with it. When no slot is given, the release goes to slot 1 for an intra-warp source and to slot 0 otherwise.
- R9: Register 0 means no destination. It is never reserved, and a release of register 0 changes nothing.
- R10: When a reserve and a release of the same register hit the same slot in the same cycle, the register stays reserved.
- R11: Reservations in one slot never cause hazards or stalls in the other slot of the same warp, or in any slot of another warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch request for an instruction-buffer half |
| fetchWarp | input | 2 | Warp of the fetch request |
| fetchSlot | input | 1 | Half / slot requested (0 primary, 1 secondary) |
| fetchSplit | input | 4 | Split id asking for the half |
| fetchMask | input | 8 | Active lane mask of that split |
| fetchGrant | output | 1 | Fetch granted; ownership recorded at the clock edge |
| fetchStall | output | 1 | Fetch refused until the slot drains |
| ownerValid | output | 1 | Addressed fetch slot is assigned |
| ownerSplit | output | 4 | Owner split id of the addressed fetch slot |
| ownerMask | output | 8 | Owner lane mask of the addressed fetch slot |
| issueValid | input | 1 | Issue candidate present |
| issueKind | input | 2 | 0 primary, 1 intra-warp co-issue, 2 inter-warp co-issue |
| issueWarp | input | 2 | Primary warp (kinds 0, 1) or donor warp (kind 2) |
| issueSrcA | input | 6 | First source register |
| issueSrcB | input | 6 | Second source register |
| issueDst | input | 6 | Destination register, 0 for none |
| issueHazard | output | 1 | A register of the candidate is reserved in its slot |
| issueAccept | output | 1 | Candidate accepted and its destination reserved |
| relValid | input | 1 | Writeback release request |
| relWarp | input | 2 | Warp of the release |
| relSlotKnown | input | 1 | A slot was recorded with the instruction |
| relSlot | input | 1 | Recorded slot |
| relIntra | input | 1 | Source was an intra-warp co-issue |
| relReg | input | 6 | Register to release |

## Verification
Writeback release and issue reservation can hit the same warp, slot and register in one edge. A fetch request can also meet the release that finally drains its slot. The bench forces the first case with directed cycles and random traffic over a few hot registers. It releases a register that is not reserved while an accepted issue reserves it, then expects a hazard on that register in the next cycle. For the second case, the bench expects a stall in the cycle of the last release and a grant in the cycle after. A reference model in the bench applies the release before the reserve, so that the reserve wins.

// File: rtl/sbSlotPkg.sv
package sbSlotPkg;

  typedef enum logic [1:0] {
    ISSUE_PRIMARY = 2'd0,
    ISSUE_INTRA   = 2'd1,
    ISSUE_INTER   = 2'd2
  } issueKind_e;

  // Strobes and slot selects handed from control to datapath.
  typedef struct packed {
    logic fetchWr;
    logic fetchSlot;
    logic rsvWr;
    logic issueSlot;
    logic relWr;
    logic relSlot;
  } sbStrobes_t;

endpackage

// File: rtl/sbSlotData.sv
module sbSlotData
  import sbSlotPkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 64,
  parameter int SPLIT_W   = 4,
  parameter int LANES     = 8,
  localparam int WARP_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int REG_W     = $clog2(NUM_REGS),
  localparam int NUM_SLOTS = NUM_WARPS * 2,
  localparam int IDX_W     = WARP_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  sbStrobes_t         strobes,
  input  logic [WARP_W-1:0]  fetchWarp,
  input  logic [SPLIT_W-1:0] fetchSplit,
  input  logic [LANES-1:0]   fetchMask,
  input  logic [WARP_W-1:0]  issueWarp,
  input  logic [REG_W-1:0]   srcA,
  input  logic [REG_W-1:0]   srcB,
  input  logic [REG_W-1:0]   dst,
  input  logic [WARP_W-1:0]  relWarp,
  input  logic [REG_W-1:0]   relReg,
  output logic               ownAsg,
  output logic [SPLIT_W-1:0] ownSplit,
  output logic [LANES-1:0]   ownMask,
  output logic               ownClean,
  output logic               issueBusy
);

  logic [NUM_REGS-1:0] resvVec  [NUM_SLOTS];
  logic                asgFlag  [NUM_SLOTS];
  logic [SPLIT_W-1:0]  ownerId  [NUM_SLOTS];
  logic [LANES-1:0]    ownerLn  [NUM_SLOTS];
  logic                slotClean[NUM_SLOTS];

  logic [IDX_W-1:0] fIdx, iIdx, rIdx;
  assign fIdx = {fetchWarp, strobes.fetchSlot};
  assign iIdx = {issueWarp, strobes.issueSlot};
  assign rIdx = {relWarp,   strobes.relSlot};

  // Reservation vectors: release applied first, reserve overrides.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) resvVec[s] <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        for (int r = 1; r < NUM_REGS; r++) begin
          if (strobes.rsvWr && iIdx == IDX_W'(s) && dst == REG_W'(r))
            resvVec[s][r] <= 1'b1;
          else if (strobes.relWr && rIdx == IDX_W'(s) && relReg == REG_W'(r))
            resvVec[s][r] <= 1'b0;
        end
        resvVec[s][0] <= 1'b0;
      end
    end
  end

  // Ownership table.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        asgFlag[s] <= 1'b0;
        ownerId[s] <= '0;
        ownerLn[s] <= '0;
      end
    end else if (strobes.fetchWr) begin
      asgFlag[fIdx] <= 1'b1;
      ownerId[fIdx] <= fetchSplit;
      ownerLn[fIdx] <= fetchMask;
    end
  end

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
      assign slotClean[g] = ~|resvVec[g];

      p_no_zero_reg_r9: assert property (@(posedge clk) disable iff (!rstN)
        !resvVec[g][0]);
    end
  endgenerate

  assign ownAsg    = asgFlag[fIdx];
  assign ownSplit  = ownerId[fIdx];
  assign ownMask   = ownerLn[fIdx];
  assign ownClean  = slotClean[fIdx];
  assign issueBusy = resvVec[iIdx][srcA] | resvVec[iIdx][srcB] | resvVec[iIdx][dst];

  p_reserve_lands_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rsvWr |=> resvVec[$past(iIdx)][$past(dst)]);

  p_handoff_clean_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fetchWr && asgFlag[fIdx] && ownerId[fIdx] != fetchSplit |-> slotClean[fIdx]);

  p_owner_recorded_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fetchWr |=> asgFlag[$past(fIdx)] && ownerId[$past(fIdx)] == $past(fetchSplit));

endmodule

// File: rtl/sbSlotCtrl.sv
module sbSlotCtrl
  import sbSlotPkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int SPLIT_W  = 4,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchValid,
  input  logic               fetchSlot,
  input  logic [SPLIT_W-1:0] fetchSplit,
  input  logic               ownAsg,
  input  logic [SPLIT_W-1:0] ownSplit,
  input  logic               ownClean,
  input  logic               issueValid,
  input  logic [1:0]         issueKind,
  input  logic [REG_W-1:0]   issueDst,
  input  logic               issueBusy,
  input  logic               relValid,
  input  logic               relSlotKnown,
  input  logic               relSlot,
  input  logic               relIntra,
  input  logic [REG_W-1:0]   relReg,
  output sbStrobes_t         strobes,
  output logic               fetchGrant,
  output logic               fetchStall,
  output logic               issueAccept
);

  issueKind_e kind;
  logic       ownerDiffers;

  assign kind         = issueKind_e'(issueKind);
  assign ownerDiffers = ownAsg && (ownSplit != fetchSplit);
  assign fetchStall   = fetchValid && ownerDiffers && !ownClean;
  assign fetchGrant   = fetchValid && !fetchStall;
  assign issueAccept  = issueValid && !issueBusy;

  always_comb begin
    strobes.fetchWr   = fetchGrant;
    strobes.fetchSlot = fetchSlot;
    strobes.issueSlot = (kind == ISSUE_INTRA);
    strobes.rsvWr     = issueAccept && (issueDst != '0);
    strobes.relWr     = relValid && (relReg != '0);
    strobes.relSlot   = relSlotKnown ? relSlot : relIntra;
  end

  p_stall_only_dirty_r3: assert property (@(posedge clk) disable iff (!rstN)
    fetchStall |-> ownAsg && !ownClean && !fetchGrant);

  p_same_split_free_r4: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && ownAsg && ownSplit == fetchSplit |-> fetchGrant);

  p_intra_slot_one_r6: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && issueKind == 2'd1 |-> strobes.issueSlot);

  p_default_slot_r8: assert property (@(posedge clk) disable iff (!rstN)
    relValid && !relSlotKnown |-> strobes.relSlot == relIntra);

  p_hazard_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    issueBusy |-> !strobes.rsvWr);

endmodule

// File: rtl/sb_split_slots.sv
module sb_split_slots
  import sbSlotPkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 64,
  parameter int SPLIT_W   = 4,
  parameter int LANES     = 8,
  localparam int WARP_W   = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchValid,
  input  logic [WARP_W-1:0]  fetchWarp,
  input  logic               fetchSlot,
  input  logic [SPLIT_W-1:0] fetchSplit,
  input  logic [LANES-1:0]   fetchMask,
  output logic               fetchGrant,
  output logic               fetchStall,
  output logic               ownerValid,
  output logic [SPLIT_W-1:0] ownerSplit,
  output logic [LANES-1:0]   ownerMask,
  input  logic               issueValid,
  input  logic [1:0]         issueKind,
  input  logic [WARP_W-1:0]  issueWarp,
  input  logic [REG_W-1:0]   issueSrcA,
  input  logic [REG_W-1:0]   issueSrcB,
  input  logic [REG_W-1:0]   issueDst,
  output logic               issueHazard,
  output logic               issueAccept,
  input  logic               relValid,
  input  logic [WARP_W-1:0]  relWarp,
  input  logic               relSlotKnown,
  input  logic               relSlot,
  input  logic               relIntra,
  input  logic [REG_W-1:0]   relReg
);

  sbStrobes_t strobes;
  logic       ownClean;
  logic       issueBusy;

  sbSlotCtrl #(.NUM_REGS(NUM_REGS), .SPLIT_W(SPLIT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchSlot(fetchSlot), .fetchSplit(fetchSplit),
    .ownAsg(ownerValid), .ownSplit(ownerSplit), .ownClean(ownClean),
    .issueValid(issueValid), .issueKind(issueKind), .issueDst(issueDst),
    .issueBusy(issueBusy),
    .relValid(relValid), .relSlotKnown(relSlotKnown), .relSlot(relSlot),
    .relIntra(relIntra), .relReg(relReg),
    .strobes(strobes), .fetchGrant(fetchGrant), .fetchStall(fetchStall),
    .issueAccept(issueAccept)
  );

  sbSlotData #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .SPLIT_W(SPLIT_W),
               .LANES(LANES)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .fetchWarp(fetchWarp), .fetchSplit(fetchSplit), .fetchMask(fetchMask),
    .issueWarp(issueWarp), .srcA(issueSrcA), .srcB(issueSrcB), .dst(issueDst),
    .relWarp(relWarp), .relReg(relReg),
    .ownAsg(ownerValid), .ownSplit(ownerSplit), .ownMask(ownerMask),
    .ownClean(ownClean), .issueBusy(issueBusy)
  );

  assign issueHazard = issueValid && issueBusy;

  p_accept_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(issueAccept && issueHazard));

endmodule

// File: tb/tb_sb_split_slots.sv
`timescale 1ns/1ps
module tb_sb_split_slots;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic       fetchValid, fetchSlot, fetchGrant, fetchStall, ownerValid;
  logic [1:0] fetchWarp;
  logic [3:0] fetchSplit, ownerSplit;
  logic [7:0] fetchMask, ownerMask;
  logic       issueValid, issueHazard, issueAccept;
  logic [1:0] issueKind, issueWarp;
  logic [5:0] issueSrcA, issueSrcB, issueDst;
  logic       relValid, relSlotKnown, relSlot, relIntra;
  logic [1:0] relWarp;
  logic [5:0] relReg;

  sb_split_slots dut (.*);

  int checks = 0;
  int fails  = 0;

  logic [63:0] mResv [8];
  logic        mAsg  [8];
  logic [3:0]  mOwn  [8];
  logic [7:0]  mMask [8];

  function automatic int slotIdx(logic [1:0] w, logic s);
    return int'(w) * 2 + int'(s);
  endfunction

  function automatic logic kindSlot(logic [1:0] k);
    return (k == 2'd1);
  endfunction

  function automatic logic expBusy();
    int i;
    i = slotIdx(issueWarp, kindSlot(issueKind));
    return mResv[i][issueSrcA] | mResv[i][issueSrcB] | mResv[i][issueDst];
  endfunction

  function automatic logic expStall();
    int i;
    i = slotIdx(fetchWarp, fetchSlot);
    return fetchValid && mAsg[i] && mOwn[i] != fetchSplit && mResv[i] != 64'd0;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    fetchValid = 0; fetchWarp = 0; fetchSlot = 0; fetchSplit = 0; fetchMask = 0;
    issueValid = 0; issueKind = 0; issueWarp = 0;
    issueSrcA = 0; issueSrcB = 0; issueDst = 0;
    relValid = 0; relWarp = 0; relSlotKnown = 0; relSlot = 0; relIntra = 0; relReg = 0;
  endtask

  // Inputs are set after a falling edge; compare, update model, cross the rising edge.
  task automatic step(string tag);
    int fi, ii, ri;
    logic st, busy;
    #1;
    fi = slotIdx(fetchWarp, fetchSlot);
    st = expStall();
    busy = expBusy();
    chk(tag, "fetchStall",  fetchStall,  st);
    chk(tag, "fetchGrant",  fetchGrant,  fetchValid && !st);
    chk(tag, "ownerValid",  ownerValid,  mAsg[fi]);
    chk(tag, "ownerSplit",  ownerSplit,  mOwn[fi]);
    chk(tag, "ownerMask",   ownerMask,   mMask[fi]);
    chk(tag, "issueHazard", issueHazard, issueValid && busy);
    chk(tag, "issueAccept", issueAccept, issueValid && !busy);
    if (fetchValid && !st) begin
      mAsg[fi] = 1'b1; mOwn[fi] = fetchSplit; mMask[fi] = fetchMask;
    end
    if (relValid && relReg != 0) begin
      ri = slotIdx(relWarp, relSlotKnown ? relSlot : relIntra);
      mResv[ri][relReg] = 1'b0;
    end
    if (issueValid && !busy && issueDst != 0) begin
      ii = slotIdx(issueWarp, kindSlot(issueKind));
      mResv[ii][issueDst] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doFetch(logic [1:0] w, logic s, logic [3:0] sp, logic [7:0] m);
    fetchValid = 1; fetchWarp = w; fetchSlot = s; fetchSplit = sp; fetchMask = m;
  endtask

  task automatic doIssue(logic [1:0] k, logic [1:0] w, logic [5:0] a, logic [5:0] b, logic [5:0] d);
    issueValid = 1; issueKind = k; issueWarp = w; issueSrcA = a; issueSrcB = b; issueDst = d;
  endtask

  task automatic doRel(logic [1:0] w, logic known, logic s, logic intra, logic [5:0] r);
    relValid = 1; relWarp = w; relSlotKnown = known; relSlot = s; relIntra = intra; relReg = r;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < 8; i++) begin
      mResv[i] = '0; mAsg[i] = 0; mOwn[i] = 0; mMask[i] = 0;
    end
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: every slot empty and unowned after reset
    for (int w = 0; w < 4; w++) begin
      for (int s = 0; s < 2; s++) begin
        idle(); fetchWarp = 2'(w); fetchSlot = 1'(s);
        doIssue(2'(s), 2'(w), 6'd5, 6'd9, 6'd0); step("R1");
      end
    end

    // R5 grant into an unassigned slot, then R2 the owner shows up
    idle(); doFetch(2'd1, 1'b0, 4'd3, 8'hA5); step("R5");
    idle(); fetchWarp = 2'd1; step("R2");

    // R7 reserve r5 in slot 0 of warp 1
    idle(); doIssue(2'd0, 2'd1, 6'd1, 6'd2, 6'd5); step("R7");
    idle(); doIssue(2'd0, 2'd1, 6'd5, 6'd2, 6'd6); step("R7");
    // R3 different split stalls, R4 owner split passes
    idle(); doFetch(2'd1, 1'b0, 4'd4, 8'h0F); step("R3");
    idle(); doFetch(2'd1, 1'b0, 4'd3, 8'hA5); step("R4");
    // R3 drain in the same cycle as the request: still stalls, then granted
    idle(); doRel(2'd1, 1'b1, 1'b0, 1'b0, 6'd5); doFetch(2'd1, 1'b0, 4'd4, 8'h0F); step("R3");
    idle(); doFetch(2'd1, 1'b0, 4'd4, 8'h0F); step("R3");
    idle(); fetchWarp = 2'd1; step("R2");

    // R6 intra uses slot 1; R11 slot 0 unaffected
    idle(); doIssue(2'd1, 2'd1, 6'd0, 6'd0, 6'd9); step("R6");
    idle(); doIssue(2'd0, 2'd1, 6'd9, 6'd0, 6'd0); step("R11");
    idle(); doIssue(2'd1, 2'd1, 6'd9, 6'd0, 6'd0); step("R6");
    // R6 inter uses donor slot 0
    idle(); doIssue(2'd2, 2'd2, 6'd0, 6'd0, 6'd7); step("R6");
    idle(); doIssue(2'd0, 2'd2, 6'd0, 6'd7, 6'd0); step("R6");
    idle(); doIssue(2'd0, 2'd3, 6'd0, 6'd7, 6'd0); step("R11");
    // R8 unrecorded intra release goes to slot 1
    idle(); doRel(2'd1, 1'b0, 1'b0, 1'b1, 6'd9); step("R8");
    idle(); doIssue(2'd1, 2'd1, 6'd9, 6'd0, 6'd0); step("R8");
    // R8 unrecorded non-intra release goes to slot 0
    idle(); doRel(2'd2, 1'b0, 1'b1, 1'b0, 6'd7); step("R8");
    idle(); doIssue(2'd0, 2'd2, 6'd7, 6'd0, 6'd0); step("R8");
    // R9 destination 0 reserves nothing
    idle(); doIssue(2'd0, 2'd0, 6'd0, 6'd0, 6'd0); step("R9");
    idle(); doIssue(2'd0, 2'd0, 6'd0, 6'd0, 6'd0); doRel(2'd0, 1'b1, 1'b0, 1'b0, 6'd0); step("R9");
    // R10 release and reserve of r12 meet in slot 0 of warp 3
    idle(); doIssue(2'd0, 2'd3, 6'd0, 6'd0, 6'd12); doRel(2'd3, 1'b1, 1'b0, 1'b0, 6'd12); step("R10");
    idle(); doIssue(2'd0, 2'd3, 6'd12, 6'd0, 6'd0); step("R10");

    // Random traffic over a few hot registers
    for (int n = 0; n < 4000; n++) begin
      idle();
      if ($urandom_range(0, 2) != 0)
        doFetch(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                4'($urandom_range(0, 3)), 8'($urandom));
      if ($urandom_range(0, 1) != 0)
        doIssue(2'($urandom_range(0, 2)), 2'($urandom_range(0, 3)),
                6'($urandom_range(0, 7)), 6'($urandom_range(0, 7)), 6'($urandom_range(0, 7)));
      if ($urandom_range(0, 3) != 0)
        doRel(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 6'($urandom_range(0, 7)));
      step("R3/R4/R7/R8/R10");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule